// File: doc/BRIEF.md
# Byte-Strobed Burst Write Memory Slave

This block is the write half of a memory-backed AXI4 slave. It takes one burst address at a time, collects exactly the number of data beats that the burst length announces, and merges each beat into an internal byte array under control of the per-lane write strobes. Once the final beat is in, it returns a single write response that carries the ID of the address that opened the burst. The array is indexed by word: the beat address is divided by the bus width in bytes and reduced modulo the number of words, so any address aliases into the array.

A three-state controller sequences the work. ST_IDLE offers the address channel. It moves to ST_BEAT when an address is accepted (transition T_ACCEPT). ST_BEAT offers the data channel and stays there for every beat except the last (T_NEXT). It moves to ST_RESP on the final beat (T_LAST). ST_RESP holds the response until the master takes it, then returns to ST_IDLE (T_DONE). An address generator steps the beat address according to the burst kind: fixed, incrementing, or wrapping. Each data beat is checked for correct last-flag placement, and any misplacement raises a one-cycle framing flag. A combinational word port lets the companion read logic observe the array.

Top module: `axw_write_slave`

## Requirements
- R1: After a synchronous active-high reset, s_awready is 1, s_wready is 0, s_bvalid is 0 and frame_err is 0.
- R2: s_awready is 1 only while no burst is open. s_wready is 1 only while a burst is open and no response is pending. s_awready, s_wready and s_bvalid are never high together in any pairing.
- R3: A burst whose s_awlen is L completes after exactly L+1 accepted data beats. s_bvalid then rises in the cycle after the final beat, with s_bid equal to the burst's s_awid and s_bresp equal to 2'b00.
- R4: Byte lane i of s_wdata is bits [8i+7:8i]. It is written only when s_wstrb[i] is 1, and a lane whose strobe is 0 keeps its old contents.
- R5: The bytes per beat are 2^s_awsize, with s_awsize no larger than log2 of the bus width in bytes. The first beat address is s_awaddr rounded down to a multiple of that size. With s_awburst 2'b01 (or the reserved 2'b11), every later beat adds that size.
- R6: With s_awburst 2'b00, every beat of the burst uses the same address.
- R7: With s_awburst 2'b10, the address steps as for an incrementing burst. When it reaches the upper edge of the region that is aligned to (size × beats) and contains s_awaddr, it wraps to the lower edge of that region.
- R8: A beat lands in word (address / bytes per word) modulo the number of words. peek_word bit [8i+7:8i] shows byte i of word peek_row.
- R9: frame_err is 1 in the cycle after an accepted beat whose s_wlast differs from "this is the final beat". It is 0 after every correctly flagged beat. The burst still completes on its beat count.
- R10: A reset in the middle of a burst or with a response pending closes the burst and drops the response. Bytes already written stay in the array.
- R11: While s_bvalid is 1 and s_bready is 0, s_bvalid stays 1 and s_bid stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_awid | input | ID_W | Burst ID |
| s_awaddr | input | ADDR_W | Burst start byte address |
| s_awlen | input | 8 | Beats minus one |
| s_awsize | input | 3 | log2 of bytes per beat |
| s_awburst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping |
| s_awvalid | input | 1 | Address valid |
| s_awready | output | 1 | Address accepted |
| s_wdata | input | DATA_W | Beat data, little-endian lanes |
| s_wstrb | input | DATA_W/8 | Per-lane write enables |
| s_wlast | input | 1 | Final-beat flag from the master |
| s_wvalid | input | 1 | Data valid |
| s_wready | output | 1 | Data accepted |
| s_bid | output | ID_W | Response ID |
| s_bresp | output | 2 | Response code, always 00 |
| s_bvalid | output | 1 | Response valid |
| s_bready | input | 1 | Response taken |
| frame_err | output | 1 | Last-flag misplacement pulse |
| peek_row | input | log2(MEM_BYTES/(DATA_W/8)) | Word index to observe |
| peek_word | output | DATA_W | Contents of word peek_row |

## Verification
An address handshake at one rising edge shows s_wready at the next sample point. Each beat commits to the array on its own edge and is visible on peek_word at once. s_bvalid appears one edge after the final beat, and frame_err is registered, so it is due in the same cycle as the bus state that follows the offending beat. The bench drives on falling edges and samples each result at the falling edge right after the edge that produces it. It sweeps all three burst kinds, every legal beat size, four burst lengths and many start addresses. After each burst it compares the whole array against a byte model that walks the beat addresses with its own boundary arithmetic.

// File: rtl/axw_pkg.sv
package axw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_RESP = 2'd2
    } axw_state_e;

    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] BURST_WRAP  = 2'b10;
    localparam logic [1:0] RESP_OKAY   = 2'b00;
endpackage

// File: rtl/axw_addr_step.sv
module axw_addr_step #(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 2,
    parameter int ROW_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        len_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        burst_i,
    output logic [ROW_W-1:0]  row_o
);
    import axw_pkg::*;

    logic [ADDR_W-1:0] cur_q, nb_q, mask_q, lower_q;
    logic [1:0]        kind_q;
    logic [ADDR_W-1:0] nb_d, total_d, sum;

    always_comb begin
        nb_d    = ADDR_W'(1) << size_i;
        total_d = (ADDR_W'(len_i) + ADDR_W'(1)) << size_i;
        sum     = cur_q + nb_q;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            cur_q   <= addr_i & ~(nb_d - ADDR_W'(1));
            nb_q    <= nb_d;
            mask_q  <= total_d - ADDR_W'(1);
            lower_q <= addr_i & ~(total_d - ADDR_W'(1));
            kind_q  <= burst_i;
        end else if (step) begin
            unique case (kind_q)
                BURST_FIXED: cur_q <= cur_q;
                BURST_WRAP:  cur_q <= lower_q | (sum & mask_q);
                default:     cur_q <= sum;
            endcase
        end
    end

    assign row_o = cur_q[LANE_W +: ROW_W];

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && !load && kind_q == BURST_FIXED) |=> $stable(cur_q)); // R6
endmodule

// File: rtl/axw_byte_mem.sv
module axw_byte_mem #(
    parameter int LANES = 4,
    parameter int ROWS  = 64,
    parameter int ROW_W = 6
) (
    input  logic               clk,
    input  logic               we,
    input  logic [ROW_W-1:0]   wr_row,
    input  logic [LANES-1:0]   wr_strb,
    input  logic [8*LANES-1:0] wr_data,
    input  logic [ROW_W-1:0]   rd_row,
    output logic [8*LANES-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bytes_q [ROWS];

        always_ff @(posedge clk) begin
            if (we && wr_strb[g]) begin
                bytes_q[wr_row] <= wr_data[8*g +: 8];
            end
        end

        assign rd_data[8*g +: 8] = bytes_q[rd_row];
    end
endmodule

// File: rtl/axw_write_slave.sv
module axw_write_slave #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int MEM_BYTES = 256
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [ID_W-1:0]                           s_awid,
    input  logic [ADDR_W-1:0]                         s_awaddr,
    input  logic [7:0]                                s_awlen,
    input  logic [2:0]                                s_awsize,
    input  logic [1:0]                                s_awburst,
    input  logic                                      s_awvalid,
    output logic                                      s_awready,
    input  logic [DATA_W-1:0]                         s_wdata,
    input  logic [DATA_W/8-1:0]                       s_wstrb,
    input  logic                                      s_wlast,
    input  logic                                      s_wvalid,
    output logic                                      s_wready,
    output logic [ID_W-1:0]                           s_bid,
    output logic [1:0]                                s_bresp,
    output logic                                      s_bvalid,
    input  logic                                      s_bready,
    output logic                                      frame_err,
    input  logic [$clog2(MEM_BYTES/(DATA_W/8))-1:0]   peek_row,
    output logic [DATA_W-1:0]                         peek_word
);
    import axw_pkg::*;

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int ROWS   = MEM_BYTES / LANES;
    localparam int ROW_W  = $clog2(ROWS);

    axw_state_e       state_q, state_d;
    logic [7:0]       left_q;
    logic [ID_W-1:0]  id_q;
    logic             err_q;
    logic             aw_fire, w_fire, last_beat;
    logic [ROW_W-1:0] row;

    assign aw_fire   = s_awvalid && s_awready;
    assign w_fire    = s_wvalid && s_wready;
    assign last_beat = (left_q == 8'd0);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (s_awvalid) state_d = ST_BEAT;
            ST_BEAT: if (s_wvalid && last_beat) state_d = ST_RESP;
            ST_RESP: if (s_bready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and burst bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            id_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= w_fire && (s_wlast != last_beat);
            if (aw_fire) begin
                left_q <= s_awlen;
                id_q   <= s_awid;
            end else if (w_fire && !last_beat) begin
                left_q <= left_q - 8'd1;
            end
        end
    end

    // outputs
    always_comb begin
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_bvalid  = 1'b0;
        unique case (state_q)
            ST_IDLE: s_awready = 1'b1;
            ST_BEAT: s_wready  = 1'b1;
            ST_RESP: s_bvalid  = 1'b1;
            default: ;
        endcase
        s_bid     = id_q;
        s_bresp   = RESP_OKAY;
        frame_err = err_q;
    end

    axw_addr_step #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .ROW_W(ROW_W)) u_step (
        .clk     (clk),
        .rst     (rst),
        .load    (aw_fire),
        .step    (w_fire),
        .addr_i  (s_awaddr),
        .len_i   (s_awlen),
        .size_i  (s_awsize),
        .burst_i (s_awburst),
        .row_o   (row)
    );

    axw_byte_mem #(.LANES(LANES), .ROWS(ROWS), .ROW_W(ROW_W)) u_mem (
        .clk     (clk),
        .we      (w_fire),
        .wr_row  (row),
        .wr_strb (s_wstrb),
        .wr_data (s_wdata),
        .rd_row  (peek_row),
        .rd_data (peek_word)
    );

    AST_AW_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        s_awready |-> (!s_wready && !s_bvalid)); // R2
    AST_W_NO_PENDING_B: assert property (@(posedge clk) disable iff (rst)
        s_wready |-> !s_bvalid); // R2
    AST_B_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(s_bvalid) |-> $past(w_fire && last_beat)); // R3
    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid))); // R11
    AST_ERR_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(w_fire)); // R9
    AST_SIZE_FITS: assert property (@(posedge clk) disable iff (rst)
        aw_fire |-> (int'(s_awsize) <= LANE_W)); // R5
endmodule

// File: tb/tb_axw_write_slave.sv
module tb_axw_write_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  awid = '0;
    logic [15:0] awaddr = '0;
    logic [7:0]  awlen = '0;
    logic [2:0]  awsize = '0;
    logic [1:0]  awburst = '0;
    logic        awvalid = 1'b0, awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wlast = 1'b0, wvalid = 1'b0, wready;
    logic [3:0]  bid;
    logic [1:0]  bresp;
    logic        bvalid, bready = 1'b0, ferr;
    logic [5:0]  prow = '0;
    logic [31:0] pword;

    int checks = 0, fails = 0;
    logic [7:0] model [256];

    always #5 clk = ~clk;

    axw_write_slave dut (
        .clk(clk), .rst(rst), .s_awid(awid), .s_awaddr(awaddr), .s_awlen(awlen),
        .s_awsize(awsize), .s_awburst(awburst), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wlast(wlast), .s_wvalid(wvalid),
        .s_wready(wready), .s_bid(bid), .s_bresp(bresp), .s_bvalid(bvalid),
        .s_bready(bready), .frame_err(ferr), .peek_row(prow), .peek_word(pword)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(awready == 1'b1, req, 32'(awready), 1);
        chk(wready == 1'b0, req, 32'(wready), 0);
        chk(bvalid == 1'b0, req, 32'(bvalid), 0);
    endtask

    task automatic check_mem(input string req);
        for (int r = 0; r < 64; r++) begin
            prow = 6'(r);
            #1;
            chk(pword == {model[r*4+3], model[r*4+2], model[r*4+1], model[r*4]},
                req, pword, {model[r*4+3], model[r*4+2], model[r*4+1], model[r*4]});
        end
    endtask

    // Called at a falling edge with the design idle; returns at a falling edge in beat state.
    task automatic send_aw(input logic [3:0] id, input logic [15:0] a, input logic [7:0] l,
                           input logic [2:0] s, input logic [1:0] bt);
        awid = id; awaddr = a; awlen = l; awsize = s; awburst = bt; awvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0;
        chk(wready == 1'b1 && awready == 1'b0, "R2", {awready, wready}, 32'b01);
    endtask

    task automatic send_beat(input logic [31:0] d, input logic [3:0] st, input logic lst);
        wdata = d; wstrb = st; wlast = lst; wvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wvalid = 1'b0; wlast = 1'b0;
    endtask

    task automatic model_write(input int adr, input logic [31:0] d, input logic [3:0] st);
        int row;
        row = (adr / 4) % 64;
        for (int i = 0; i < 4; i++) if (st[i]) model[row*4+i] = d[8*i +: 8];
    endtask

    task automatic take_resp(input logic [3:0] id, input string req);
        chk(bvalid == 1'b1 && wready == 1'b0, req, {bvalid, wready}, 32'b10);
        chk(bid == id, req, bid, id);
        chk(bresp == 2'b00, req, bresp, 0);
        bready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bready = 1'b0;
        check_idle("R2");
    endtask

    task automatic run_burst(input int idx, input logic [15:0] a, input int l, input int s, input int bt);
        int nb, total, lower, upper, cur;
        logic [31:0] d;
        logic [3:0] st;
        nb = 1 << s;
        total = nb * (l + 1);
        lower = (int'(a) / total) * total;
        upper = lower + total;
        cur = (int'(a) / nb) * nb;
        send_aw(4'(idx), a, 8'(l), 3'(s), 2'(bt));
        for (int b = 0; b <= l; b++) begin
            d = 32'(idx) * 32'h01030507 + 32'(b) * 32'h1F2E3D4C + 32'h5A;
            st = 4'((idx + b * 3) % 16);
            model_write(cur, d, st);
            send_beat(d, st, b == l);
            chk(ferr == 1'b0, "R9", 32'(ferr), 0);
            if (b < l) chk(wready == 1'b1, "R3", 32'(wready), 1);
            if (bt != 0) cur = cur + nb;
            if (bt == 2 && cur == upper) cur = lower;
        end
        take_resp(4'(idx), "R3");
        case (bt)
            0: check_mem("R6");
            2: check_mem("R7");
            default: check_mem("R5");
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int idx;
        logic [3:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1");
        chk(ferr == 1'b0, "R1", 32'(ferr), 0);

        // fill the array: 64 full-width incrementing beats from 0
        send_aw(4'hA, 16'h0000, 8'd63, 3'd2, 2'b01);
        for (int b = 0; b < 64; b++) begin
            model_write(b * 4, 32'hC0DE0000 + 32'(b), 4'hF);
            send_beat(32'hC0DE0000 + 32'(b), 4'hF, b == 63);
        end
        take_resp(4'hA, "R3");
        check_mem("R8");

        // sweep sizes, kinds, lengths and addresses (addresses above 256 alias, R8)
        idx = 1;
        for (int s = 0; s <= 2; s++)
            for (int bt = 0; bt <= 2; bt++)
                for (int li = 0; li < 4; li++) begin
                    run_burst(idx, 16'((idx * 16'h01D3 + 3 * s) & 16'hFFFF), (1 << li) - 1, s, bt);
                    idx++;
                end

        // reserved burst code acts as incrementing (R5)
        run_burst(7, 16'h0305, 3, 1, 3);

        // strobe lanes: zero strobe keeps everything, single lanes land in place (R4)
        send_aw(4'h2, 16'h0040, 8'd4, 3'd2, 2'b01);
        for (int b = 0; b < 5; b++) begin
            logic [3:0] st;
            st = (b == 0) ? 4'h0 : 4'(1 << (b - 1));
            model_write(16'h40 + b * 4, 32'h11223344 ^ 32'(b), st);
            send_beat(32'h11223344 ^ 32'(b), st, b == 4);
        end
        take_resp(4'h2, "R3");
        check_mem("R4");

        // early last flag (R9): len 1, last on beat 0
        send_aw(4'h3, 16'h0010, 8'd1, 3'd2, 2'b01);
        model_write(16'h10, 32'hDEAD0001, 4'hF);
        send_beat(32'hDEAD0001, 4'hF, 1'b1);
        chk(ferr == 1'b1, "R9", 32'(ferr), 1);
        chk(wready == 1'b1, "R9", 32'(wready), 1);
        model_write(16'h14, 32'hDEAD0002, 4'hF);
        send_beat(32'hDEAD0002, 4'hF, 1'b1);
        chk(ferr == 1'b0, "R9", 32'(ferr), 0);
        take_resp(4'h3, "R9");

        // missing last flag on the final beat (R9)
        send_aw(4'h4, 16'h0020, 8'd0, 3'd2, 2'b01);
        model_write(16'h20, 32'hBEEF0003, 4'hF);
        send_beat(32'hBEEF0003, 4'hF, 1'b0);
        chk(ferr == 1'b1, "R9", 32'(ferr), 1);
        take_resp(4'h4, "R9");
        check_mem("R9");

        // response held while not taken (R11)
        send_aw(4'h9, 16'h0080, 8'd0, 3'd2, 2'b00);
        model_write(16'h80, 32'h0BADF00D, 4'hF);
        send_beat(32'h0BADF00D, 4'hF, 1'b1);
        held = bid;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(bvalid == 1'b1 && bid == held, "R11", {bvalid, bid}, {1'b1, held});
        end
        take_resp(4'h9, "R11");

        // reset mid-burst keeps written bytes (R10)
        send_aw(4'h5, 16'h00C0, 8'd3, 3'd2, 2'b01);
        model_write(16'hC0, 32'h600DCAFE, 4'hF);
        send_beat(32'h600DCAFE, 4'hF, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_idle("R10");
        check_mem("R10");

        // reset with a response pending (R10)
        send_aw(4'h6, 16'h00D0, 8'd0, 3'd2, 2'b01);
        model_write(16'hD0, 32'h12345678, 4'hF);
        send_beat(32'h12345678, 4'hF, 1'b1);
        chk(bvalid == 1'b1, "R10", 32'(bvalid), 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_idle("R10");
        @(negedge clk);
        chk(bvalid == 1'b0, "R10", 32'(bvalid), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule